// File: doc/BRIEF.md
# Trigger-Frozen Two-Page Hit Recorder

This block keeps a rolling history of one timing channel. On every clock it stores a 9-bit word: a hit flag and an 8-bit fine-time code. Recording never pauses, so the only dead time is the one cycle each word takes. The storage is split into two pages. Writes go to one page while the other page stays available for reading.

When a trigger is accepted, the page roles swap. The page that was being written becomes frozen, and recording carries on in the other page without losing a cycle. A read engine then walks backward through the frozen page, starting at the slot written in the trigger cycle, for a fixed window of cycles. It reports every stored hit with its distance from the trigger in cycles and its fine code.

The page selection stays locked until a restart command arrives, so the frozen data cannot be overwritten before it is read. Triggers that arrive while the page is locked, or while a readout is still running, are counted and otherwise ignored.

Top module: `trig_hit_recorder`

## Requirements
- R1: After synchronous reset the block is in this state: page_o=0, locked_o=0, busy_o=0, drop_cnt_o=0 and rd_valid_o=0.
- R2: The write pointer is 8 bits wide, starts at 0 after reset and advances by one every cycle, wrapping from 255 to 0. While reset is low, each cycle stores {hit_i, fine_i} at address {~page_o, write pointer}.
- R3: A trigger is accepted when trig_i=1, locked_o=0 and busy_o=0. On the clock edge that accepts it, page_o inverts and locked_o becomes 1. The word written on that same edge belongs to the now-frozen page, at offset 0.
- R4: locked_o stays 1 until a cycle in which restart_i=1 and no trigger is accepted; it is 0 after that edge. When restart_i and trig_i are both high while locked_o=1, the trigger is judged against the old lock value, so it is dropped.
- R5: Readout covers offsets 0 to WIN_LEN-1 in increasing order. Offset k reads frozen-page address (start - k) mod 256, where start is the write pointer at the trigger, so the walk wraps below address 0. The result for offset k is presented after the (k+1)-th clock edge that follows the accepting edge.
- R6: Only stored words whose hit flag is 1 produce rd_valid_o=1, with rd_offset_o=k and rd_fine_o equal to the stored fine code. Words written after the trigger never appear in that readout.
- R7: A trigger with trig_i=1 that is not accepted leaves page_o unchanged and adds 1 to drop_cnt_o. The counter saturates at 255.
- R8: busy_o is 1 for exactly WIN_LEN cycles after an accepted trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Hit flag for this cycle |
| fine_i | input | 8 | Fine-time code for this cycle |
| trig_i | input | 1 | Trigger request |
| restart_i | input | 1 | Releases the page lock |
| rd_valid_o | output | 1 | A stored hit is being reported |
| rd_offset_o | output | 8 | Cycles before the trigger at which the hit was stored |
| rd_fine_o | output | 8 | Fine code of the reported hit |
| busy_o | output | 1 | Readout walk in progress |
| page_o | output | 1 | Current page bit; the write page is its inverse |
| locked_o | output | 1 | Page bit is locked |
| drop_cnt_o | output | 8 | Number of ignored triggers, saturating |

## Verification
Two events can land on the same edge: a trigger and a restart. The bench raises both on one cycle while the page is locked, and expects the trigger to be dropped, the counter to go up by one, the page to stay put and the lock to clear. A second collision is a restart issued mid-readout, followed at once by a trigger. That trigger must also be dropped, because the walk is still busy.

A reference model in the bench mirrors every stored word and the page, lock and busy state. Each readout is compared against this model, entry by entry.

// File: rtl/hitrec_pkg.sv
package hitrec_pkg;
    localparam int REC_FINE_W = 8;
    localparam int REC_ADDR_W = 8;

    typedef struct packed {
        logic                  hit;
        logic [REC_FINE_W-1:0] fine;
    } rec_word_t;

    function automatic logic [REC_ADDR_W-1:0] back_addr(
        input logic [REC_ADDR_W-1:0] start,
        input logic [REC_ADDR_W-1:0] step
    );
        return start - step;
    endfunction
endpackage

// File: rtl/hitrec_page_ctrl.sv
module hitrec_page_ctrl
    import hitrec_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trig_i,
    input  logic                  restart_i,
    input  logic                  busy_i,
    output logic                  accept_o,
    output logic                  page_o,
    output logic                  locked_o,
    output logic [REC_ADDR_W-1:0] wptr_o,
    output logic [DROP_W-1:0]     drop_o
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    assign accept_o = trig_i && !locked_o && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_o   <= 1'b0;
            locked_o <= 1'b0;
            wptr_o   <= '0;
            drop_o   <= '0;
        end else begin
            wptr_o <= wptr_o + 1'b1;
            if (accept_o) begin
                page_o   <= ~page_o;
                locked_o <= 1'b1;
            end else begin
                if (restart_i)
                    locked_o <= 1'b0;
                if (trig_i && drop_o != DROP_MAX)
                    drop_o <= drop_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hitrec_store.sv
module hitrec_store
    import hitrec_pkg::*;
(
    input  logic                  clk,
    input  logic                  we_i,
    input  logic [REC_ADDR_W:0]   waddr_i,
    input  rec_word_t             wdata_i,
    input  logic [REC_ADDR_W:0]   raddr_i,
    output rec_word_t             rdata_o
);
    localparam int DEPTH = 1 << (REC_ADDR_W + 1);

    rec_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i)
            mem[waddr_i] <= wdata_i;
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/hitrec_reader.sv
module hitrec_reader
    import hitrec_pkg::*;
#(
    parameter int WIN_LEN = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept_i,
    input  logic [REC_ADDR_W-1:0] wptr_i,
    output logic [REC_ADDR_W-1:0] raddr_o,
    output logic                  busy_o,
    output logic                  step_vld_o,
    output logic [REC_ADDR_W-1:0] step_off_o
);
    localparam logic [REC_ADDR_W-1:0] LAST_STEP = REC_ADDR_W'(WIN_LEN - 1);

    logic [REC_ADDR_W-1:0] start_q;
    logic [REC_ADDR_W-1:0] step_q;

    assign raddr_o = back_addr(start_q, step_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q    <= '0;
            step_q     <= '0;
            busy_o     <= 1'b0;
            step_vld_o <= 1'b0;
            step_off_o <= '0;
        end else begin
            step_vld_o <= busy_o;
            step_off_o <= step_q;
            if (accept_i) begin
                start_q <= wptr_i;
                step_q  <= '0;
                busy_o  <= 1'b1;
            end else if (busy_o) begin
                step_q <= step_q + 1'b1;
                if (step_q == LAST_STEP)
                    busy_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/trig_hit_recorder.sv
module trig_hit_recorder
    import hitrec_pkg::*;
#(
    parameter int WIN_LEN = 16,
    parameter int DROP_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hit_i,
    input  logic [REC_FINE_W-1:0] fine_i,
    input  logic                  trig_i,
    input  logic                  restart_i,
    output logic                  rd_valid_o,
    output logic [REC_ADDR_W-1:0] rd_offset_o,
    output logic [REC_FINE_W-1:0] rd_fine_o,
    output logic                  busy_o,
    output logic                  page_o,
    output logic                  locked_o,
    output logic [DROP_W-1:0]     drop_cnt_o
);
    logic                  accept;
    logic [REC_ADDR_W-1:0] wptr;
    logic [REC_ADDR_W-1:0] raddr;
    logic                  step_vld;
    logic [REC_ADDR_W-1:0] step_off;
    rec_word_t             wword;
    rec_word_t             rword;

    assign wword = '{hit: hit_i, fine: fine_i};

    hitrec_page_ctrl #(.DROP_W(DROP_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig_i),
        .restart_i (restart_i),
        .busy_i    (busy_o),
        .accept_o  (accept),
        .page_o    (page_o),
        .locked_o  (locked_o),
        .wptr_o    (wptr),
        .drop_o    (drop_cnt_o)
    );

    hitrec_store u_store (
        .clk     (clk),
        .we_i    (!rst),
        .waddr_i ({~page_o, wptr}),
        .wdata_i (wword),
        .raddr_i ({page_o, raddr}),
        .rdata_o (rword)
    );

    hitrec_reader #(.WIN_LEN(WIN_LEN)) u_reader (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .wptr_i     (wptr),
        .raddr_o    (raddr),
        .busy_o     (busy_o),
        .step_vld_o (step_vld),
        .step_off_o (step_off)
    );

    assign rd_valid_o  = step_vld && rword.hit;
    assign rd_offset_o = step_off;
    assign rd_fine_o   = rword.fine;
endmodule

// File: rtl/trig_hit_recorder_chk.sv
module trig_hit_recorder_chk
    import hitrec_pkg::*;
#(
    parameter int WIN_LEN = 16,
    parameter int DROP_W  = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  trig_i,
    input logic                  restart_i,
    input logic                  accept,
    input logic [REC_ADDR_W-1:0] wptr,
    input logic                  page_o,
    input logic                  locked_o,
    input logic                  busy_o,
    input logic                  rd_valid_o,
    input logic [REC_ADDR_W-1:0] rd_offset_o,
    input logic [DROP_W-1:0]     drop_cnt_o
);
    localparam logic [DROP_W-1:0] DMAX = '1;

    a_r2_wptr_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> wptr == $past(wptr) + 1'b1);

    a_r3_flip_and_lock: assert property (@(posedge clk) disable iff (rst)
        accept |=> (page_o != $past(page_o)) && locked_o);

    a_r4_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (locked_o && !restart_i) |=> locked_o && $stable(page_o));

    a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
        (restart_i && !accept) |=> !locked_o);

    a_r5_offset_in_window: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> rd_offset_o < REC_ADDR_W'(WIN_LEN));

    a_r7_drop_count: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !accept && drop_cnt_o != DMAX) |=> drop_cnt_o == $past(drop_cnt_o) + 1'b1);

    a_r7_page_kept: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !accept) |=> $stable(page_o));

    a_r8_busy_rise: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_o);
endmodule

bind trig_hit_recorder trig_hit_recorder_chk #(.WIN_LEN(WIN_LEN), .DROP_W(DROP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .trig_i      (trig_i),
    .restart_i   (restart_i),
    .accept      (accept),
    .wptr        (wptr),
    .page_o      (page_o),
    .locked_o    (locked_o),
    .busy_o      (busy_o),
    .rd_valid_o  (rd_valid_o),
    .rd_offset_o (rd_offset_o),
    .drop_cnt_o  (drop_cnt_o)
);

// File: tb/trig_hit_recorder_tb.sv
module trig_hit_recorder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hit_i = 1'b0;
    logic [7:0] fine_i = '0;
    logic       trig_i = 1'b0;
    logic       restart_i = 1'b0;
    logic       rd_valid_o;
    logic [7:0] rd_offset_o;
    logic [7:0] rd_fine_o;
    logic       busy_o;
    logic       page_o;
    logic       locked_o;
    logic [7:0] drop_cnt_o;

    trig_hit_recorder #(.WIN_LEN(WIN), .DROP_W(8)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit stim_on = 0;
    int mode = 0;

    logic [8:0]  mem_m [2][256];
    logic [15:0] exp_q [$];
    logic        pg_m = 0;
    logic        lk_m = 0;
    logic [7:0]  wp_m = 0;
    logic [7:0]  drop_m = 0;
    int          rem_m = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        for (int p = 0; p < 2; p++)
            for (int a = 0; a < 256; a++)
                mem_m[p][a] = '0;
    end

    // reference model, following the requirements
    always @(posedge clk) begin
        if (rst) begin
            pg_m = 0; lk_m = 0; wp_m = 0; drop_m = 0; rem_m = 0;
        end else begin
            logic acc;
            logic wpg;
            wpg = ~pg_m;
            mem_m[wpg][wp_m] = {hit_i, fine_i};
            acc = trig_i && !lk_m && (rem_m == 0);
            if (rem_m > 0) rem_m--;
            if (acc) begin
                for (int k = 0; k < WIN; k++) begin
                    logic [8:0] e;
                    e = mem_m[wpg][8'(wp_m - 8'(k))];
                    if (e[8]) exp_q.push_back({8'(k), e[7:0]});
                end
                pg_m = ~pg_m;
                lk_m = 1;
                rem_m = WIN;
            end else begin
                if (restart_i) lk_m = 0;
                if (trig_i && drop_m != 8'hFF) drop_m++;
            end
            wp_m++;
        end
    end

    // stimulus data
    always @(negedge clk) begin
        if (stim_on) begin
            cyc++;
            hit_i  <= (mode == 1) ? 1'b1 : ((cyc % 3 == 0) || (cyc % 7 == 1));
            fine_i <= 8'(cyc * 37 + 5);
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            chk(page_o == pg_m, "R3", "page bit", page_o, pg_m);
            chk(locked_o == lk_m, "R4", "lock", locked_o, lk_m);
            chk(busy_o == (rem_m > 0), "R8", "busy", busy_o, rem_m > 0);
            chk(drop_cnt_o == drop_m, "R7", "drop count", drop_cnt_o, drop_m);
            if (rd_valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected hit offset", rd_offset_o, -1);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rd_offset_o == e[15:8], "R5", "offset", rd_offset_o, e[15:8]);
                    chk(rd_fine_o == e[7:0], "R6", "fine code", rd_fine_o, e[7:0]);
                end
            end
        end
    end

    task automatic pulse(bit t, bit r);
        @(negedge clk);
        trig_i <= t; restart_i <= r;
        @(negedge clk);
        trig_i <= 0; restart_i <= 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk(page_o == 0 && locked_o == 0 && busy_o == 0 && drop_cnt_o == 0 && rd_valid_o == 0,
            "R1", "reset state", {page_o, locked_o, busy_o, rd_valid_o}, 0);
        rst <= 0;
        stim_on = 1;
        idle(40);
        // R3 R5 R6 first capture
        pulse(1, 0);
        idle(3);
        // R7 trigger during busy and lock
        pulse(1, 0);
        idle(30);
        pulse(1, 0);
        chk(drop_cnt_o == 2, "R7", "drops after two ignored", drop_cnt_o, 2);
        // R4 restart and trigger together while locked
        pulse(1, 1);
        chk(locked_o == 0 && drop_cnt_o == 3, "R4", "collision", {locked_o, drop_cnt_o}, 3);
        idle(30);
        // R5 wrap below address 0
        while (wp_m != 8'd3) @(negedge clk);
        trig_i <= 1;
        @(negedge clk);
        trig_i <= 0;
        idle(4);
        // R7 restart during readout, trigger while still busy
        pulse(0, 1);
        pulse(1, 0);
        chk(drop_cnt_o == 4 && locked_o == 0, "R7", "busy drop", drop_cnt_o, 4);
        idle(30);
        // R6 dense hits: every offset reported
        mode = 1;
        idle(20);
        pulse(1, 0);
        idle(25);
        mode = 0;
        // R7 saturation
        @(negedge clk);
        trig_i <= 1;
        idle(300);
        trig_i <= 0;
        @(negedge clk);
        chk(drop_cnt_o == 8'hFF, "R7", "saturated", drop_cnt_o, 255);
        chk(page_o == pg_m, "R7", "page kept during drops", page_o, pg_m);
        // R2 fresh capture after long run (pointer wrapped many times)
        pulse(0, 1);
        idle(5);
        pulse(1, 0);
        idle(WIN + 5);
        chk(exp_q.size() == 0, "R6", "leftover expected hits", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule